// File: doc/BRIEF.md
# Four-Approach Demand-Driven Traffic Light Controller

This block runs the lights of a road crossing with four approaches: north-to-south, south-to-north, west-to-east and east-to-west. Each approach has one vehicle sensor bit and one 2-bit light output. A light is lit only for an approach that has asked for service. Two approaches on the same axis can be green together, but the two axes never show a non-red light at the same time. A request cannot wait forever, because service alternates between the axes.

A sensor pulse only needs to last one clock. It is stored as a pending request, and the request is dropped when that approach turns green. When the crossing is all red and requests are pending, the controller picks an axis. It then lights every pending approach on that axis. If both axes are pending, it picks the axis that was not served last. A green period lasts at least `MIN_GREEN` cycles. It ends at `MAX_GREEN` cycles if the other axis is waiting, or as soon as the minimum has passed and no lit approach still senses a vehicle. Every green light then shows yellow for `YELLOW_LEN` cycles. After that the crossing is all red for `CLEAR_LEN` cycles, plus one decision cycle, before the next grant. All times are counted in clock cycles.

Top module: `xing_ctrl`

## Requirements
- R1: In the cycle after any clock edge that samples `rst` high, all four lights read red (00).
- R2: Each light output only ever takes one of three codes: 00 red, 01 green, 10 yellow. The code 11 never appears.
- R3: When either north-south light (`lamp_ns_o`, `lamp_sn_o`) is not red, both west-east lights (`lamp_we_o`, `lamp_ew_o`) are red, and the reverse also holds.
- R4: An approach that has sensed no vehicle stays red, even while the opposite approach on its own axis is green.
- R5: From the all-red idle state, a sensor bit that is high for one clock edge makes that approach green two clock edges after the bit is first sampled, and not earlier. Sensor bit order is: bit 0 north-to-south, bit 1 south-to-north, bit 2 west-to-east, bit 3 east-to-west.
- R6: A green period lasts at least `MIN_GREEN` cycles. With no further demand it lasts exactly `MIN_GREEN` cycles. It is always followed by exactly `YELLOW_LEN` yellow cycles.
- R7: If the other axis is waiting and the lit approach keeps sensing, green ends after exactly `MAX_GREEN` cycles. After the yellow, `CLEAR_LEN`+1 all-red cycles pass before the waiting axis turns green.
- R8: If the other axis has no request, a lit approach that keeps sensing stays green for longer than `MAX_GREEN` cycles.
- R9: An approach on the axis that is already green joins the running green period. It turns green two edges after its sensor is sampled, and the approach that was already green stays green.
- R10: When both axes have requests, the axis that was not served last gets the next grant. After reset, the north-south axis counts as the one to go first.
- R11: Under arbitrary sensor traffic, every approach whose sensor goes high while it is not green turns green within 2*(`MAX_GREEN`+`YELLOW_LEN`+`CLEAR_LEN`+1)+4 cycles.
- R12: A served request is consumed. Once an approach's green period has ended and no new sensing occurs, it stays red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sense_i | input | 4 | Vehicle sensors: bit 0 N-to-S, bit 1 S-to-N, bit 2 W-to-E, bit 3 E-to-W |
| lamp_ns_o | output | 2 | North-to-south light: 00 red, 01 green, 10 yellow |
| lamp_sn_o | output | 2 | South-to-north light, same encoding |
| lamp_we_o | output | 2 | West-to-east light, same encoding |
| lamp_ew_o | output | 2 | East-to-west light, same encoding |

## Verification
The assertions assume that the sensor bits are synchronous to `clk` and settle before each rising edge. They also assume that reset is held for at least one edge before any sensing counts. The bench meets both conditions: it changes `sense_i` only on falling edges and releases reset on a falling edge after two sampled reset edges. The embedded properties can therefore rely on clean, single-sampled requests. These properties cover axis exclusion, light codes, minimum hold, the forced end at the cap, and request clearing.

// File: rtl/xing_pkg.sv
package xing_pkg;

    localparam int NDIR = 4;

    // direction index: 0 N->S, 1 S->N (axis 0), 2 W->E, 3 E->W (axis 1)
    localparam logic [NDIR-1:0] AXIS0_MASK = 4'b0011;
    localparam logic [NDIR-1:0] AXIS1_MASK = 4'b1100;

    typedef enum logic [1:0] {
        LAMP_RED    = 2'b00,
        LAMP_GREEN  = 2'b01,
        LAMP_YELLOW = 2'b10
    } lamp_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_GREEN,
        PH_AMBER,
        PH_CLEAR
    } phase_e;

    function automatic logic [NDIR-1:0] axis_mask(input logic ax);
        return ax ? AXIS1_MASK : AXIS0_MASK;
    endfunction

endpackage

// File: rtl/xing_req_latch.sv
module xing_req_latch
    import xing_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NDIR-1:0] sense_i,
    input  logic [NDIR-1:0] start_i,
    input  logic [NDIR-1:0] serve_i,
    output logic [NDIR-1:0] pend_o
);

    logic [NDIR-1:0] pend_q;

    // a request is held until its green begins; sensing while green is service
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | sense_i) & ~(start_i | serve_i);
        end
    end

    assign pend_o = pend_q;

    AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (|start_i) |=> ((pend_q & $past(start_i)) == '0)); // R12

endmodule

// File: rtl/xing_phase_seq.sv
module xing_phase_seq
    import xing_pkg::*;
#(
    parameter int unsigned MIN_GREEN  = 4,
    parameter int unsigned MAX_GREEN  = 8,
    parameter int unsigned YELLOW_LEN = 2,
    parameter int unsigned CLEAR_LEN  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NDIR-1:0] pend_i,
    input  logic [NDIR-1:0] sense_i,
    output logic [NDIR-1:0] start_o,
    output logic [NDIR-1:0] lit_o,
    output phase_e          phase_o
);

    localparam int unsigned CW = $clog2(MAX_GREEN + YELLOW_LEN + CLEAR_LEN + 1);
    localparam logic [CW-1:0] MIN_LAST = CW'(MIN_GREEN - 1);
    localparam logic [CW-1:0] MAX_LAST = CW'(MAX_GREEN - 1);
    localparam logic [CW-1:0] YEL_LAST = CW'(YELLOW_LEN - 1);
    localparam logic [CW-1:0] CLR_LAST = CW'(CLEAR_LEN - 1);

    phase_e          phase_q, phase_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [NDIR-1:0] lit_q, lit_d;
    logic            axis_q, axis_d;   // axis granted most recently
    logic [NDIR-1:0] start_m;

    logic [NDIR-1:0] own_m, oth_m, join_m;
    logic            both_req, pick, other_wait, at_cap, min_ok, own_dem, cap_hit;

    always_comb begin
        own_m      = axis_mask(axis_q);
        oth_m      = ~own_m;
        both_req   = (|(pend_i & AXIS0_MASK)) && (|(pend_i & AXIS1_MASK));
        pick       = both_req ? ~axis_q : (|(pend_i & AXIS1_MASK));
        other_wait = |(pend_i & oth_m);
        at_cap     = cnt_q >= MAX_LAST;
        min_ok     = cnt_q >= MIN_LAST;
        own_dem    = |(sense_i & lit_q);
        join_m     = pend_i & own_m & ~lit_q;
        cap_hit    = other_wait && at_cap;
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        lit_d   = lit_q;
        axis_d  = axis_q;
        start_m = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (|pend_i) begin
                    start_m = pend_i & axis_mask(pick);
                    lit_d   = start_m;
                    axis_d  = pick;
                    phase_d = PH_GREEN;
                    cnt_d   = '0;
                end
            end
            PH_GREEN: begin
                if (!cap_hit) begin
                    start_m = join_m;
                end
                lit_d = lit_q | start_m;
                if (min_ok && (cap_hit || (!own_dem && start_m == '0))) begin
                    phase_d = PH_AMBER;
                    cnt_d   = '0;
                end else if (!at_cap) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_AMBER: begin
                if (cnt_q >= YEL_LAST) begin
                    phase_d = PH_CLEAR;
                    cnt_d   = '0;
                    lit_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_CLEAR: begin
                if (cnt_q >= CLR_LAST) begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            lit_q   <= '0;
            axis_q  <= 1'b1;   // axis 0 is served first after reset
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            lit_q   <= lit_d;
            axis_q  <= axis_d;
        end
    end

    assign start_o = start_m;
    assign lit_o   = lit_q;
    assign phase_o = phase_q;

    AST_GREEN_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GREEN && cnt_q < MIN_LAST) |=> (phase_q == PH_GREEN)); // R6
    AST_GREEN_TO_AMBER: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GREEN) |=> (phase_q == PH_GREEN || phase_q == PH_AMBER)); // R6
    AST_GREEN_CAP_END: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GREEN && cap_hit) |=> (phase_q == PH_AMBER)); // R7
    AST_AMBER_NOT_GREEN: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_AMBER) |=> (phase_q != PH_GREEN)); // R7

endmodule

// File: rtl/xing_lamp_map.sv
module xing_lamp_map
    import xing_pkg::*;
(
    input  phase_e               phase_i,
    input  logic [NDIR-1:0]      lit_i,
    output logic [NDIR-1:0][1:0] lamp_o,
    output logic [NDIR-1:0]      green_o
);

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        assign green_o[g] = lit_i[g] && (phase_i == PH_GREEN);
        assign lamp_o[g]  = green_o[g] ? LAMP_GREEN :
                            (lit_i[g] && phase_i == PH_AMBER) ? LAMP_YELLOW : LAMP_RED;
    end

endmodule

// File: rtl/xing_ctrl.sv
module xing_ctrl
    import xing_pkg::*;
#(
    parameter int unsigned MIN_GREEN  = 4,
    parameter int unsigned MAX_GREEN  = 8,
    parameter int unsigned YELLOW_LEN = 2,
    parameter int unsigned CLEAR_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] sense_i,
    output logic [1:0] lamp_ns_o,
    output logic [1:0] lamp_sn_o,
    output logic [1:0] lamp_we_o,
    output logic [1:0] lamp_ew_o
);

    logic [NDIR-1:0]      pend, start, lit, green;
    logic [NDIR-1:0][1:0] lamp;
    phase_e               phase;

    xing_req_latch u_req (
        .clk     (clk),
        .rst     (rst),
        .sense_i (sense_i),
        .start_i (start),
        .serve_i (green),
        .pend_o  (pend)
    );

    xing_phase_seq #(
        .MIN_GREEN  (MIN_GREEN),
        .MAX_GREEN  (MAX_GREEN),
        .YELLOW_LEN (YELLOW_LEN),
        .CLEAR_LEN  (CLEAR_LEN)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (pend),
        .sense_i (sense_i),
        .start_o (start),
        .lit_o   (lit),
        .phase_o (phase)
    );

    xing_lamp_map u_map (
        .phase_i (phase),
        .lit_i   (lit),
        .lamp_o  (lamp),
        .green_o (green)
    );

    assign lamp_ns_o = lamp[0];
    assign lamp_sn_o = lamp[1];
    assign lamp_we_o = lamp[2];
    assign lamp_ew_o = lamp[3];

    logic ax0_on, ax1_on;
    assign ax0_on = (lamp_ns_o != 2'b00) || (lamp_sn_o != 2'b00);
    assign ax1_on = (lamp_we_o != 2'b00) || (lamp_ew_o != 2'b00);

    AST_AXIS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ax0_on && ax1_on)); // R3
    AST_LAMP_CODE: assert property (@(posedge clk) disable iff (rst)
        (lamp_ns_o != 2'b11) && (lamp_sn_o != 2'b11) &&
        (lamp_we_o != 2'b11) && (lamp_ew_o != 2'b11)); // R2
    AST_RESET_RED: assert property (@(posedge clk)
        rst |=> (!ax0_on && !ax1_on)); // R1

endmodule

// File: tb/sim_xing_ctrl.sv
module sim_xing_ctrl;
    import xing_pkg::*;

    localparam int MING  = 4;
    localparam int MAXG  = 8;
    localparam int YEL   = 2;
    localparam int CLR   = 2;
    localparam int BOUND = 2 * (MAXG + YEL + CLR + 1) + 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] sense = 4'b0000;
    logic [1:0] l_ns, l_sn, l_we, l_ew;
    logic [1:0] lam [4];

    always #5 clk = ~clk;

    xing_ctrl #(
        .MIN_GREEN (MING),
        .MAX_GREEN (MAXG),
        .YELLOW_LEN(YEL),
        .CLEAR_LEN (CLR)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .sense_i   (sense),
        .lamp_ns_o (l_ns),
        .lamp_sn_o (l_sn),
        .lamp_we_o (l_we),
        .lamp_ew_o (l_ew)
    );

    assign lam[0] = l_ns;
    assign lam[1] = l_sn;
    assign lam[2] = l_we;
    assign lam[3] = l_ew;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        sense = 4'b0000;
        repeat (2) tick();
        rst = 1'b0;
    endtask

    function automatic int all_red();
        return (l_ns == 2'b00 && l_sn == 2'b00 && l_we == 2'b00 && l_ew == 2'b00) ? 1 : 0;
    endfunction

    function automatic int green_axis();
        if (l_ns == 2'b01 || l_sn == 2'b01) return 0;
        if (l_we == 2'b01 || l_ew == 2'b01) return 1;
        return -1;
    endfunction

    task automatic count_code(input int d, input logic [1:0] code, output int n);
        n = 0;
        while (lam[d] == code && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        tick();
        // R1: reset state
        do_reset();
        chk(all_red() == 1, "R1 reset lights", all_red(), 1);

        // sweep over every nonzero one-cycle sensor pattern from reset
        for (int p = 1; p < 16; p++) begin
            logic [3:0] expm;
            do_reset();
            sense = 4'(p);
            tick();
            sense = 4'b0000;
            chk(all_red() == 1, "R5 no early green", all_red(), 1);
            tick();
            expm = ((p & 3) != 0) ? 4'(p & 3) : 4'(p & 12);
            for (int d = 0; d < 4; d++) begin
                if (expm[d])
                    chk(lam[d] == LAMP_GREEN, "R5 grant latency", int'(lam[d]), 1);
                else
                    chk(lam[d] == LAMP_RED, "R4 no demand stays red", int'(lam[d]), 0);
            end
            if ((p & 3) != 0 && (p & 12) != 0)
                chk(green_axis() == 0, "R10 axis 0 first after reset", green_axis(), 0);
        end

        // R6 and R12: single pulse, minimum hold, yellow, then stays red
        do_reset();
        sense = 4'b0001;
        tick();
        sense = 4'b0000;
        tick();
        count_code(0, LAMP_GREEN, n);
        chk(n == MING, "R6 green length", n, MING);
        count_code(0, LAMP_YELLOW, n);
        chk(n == YEL, "R6 yellow length", n, YEL);
        repeat (30) tick();
        chk(all_red() == 1, "R12 request consumed", all_red(), 1);

        // R7: cap while other axis waits, then clearance
        do_reset();
        sense = 4'b0101;
        tick();
        sense = 4'b0001;
        tick();
        count_code(0, LAMP_GREEN, n);
        chk(n == MAXG, "R7 capped green", n, MAXG);
        count_code(0, LAMP_YELLOW, n);
        chk(n == YEL, "R7 yellow after cap", n, YEL);
        n = 0;
        while (lam[2] != LAMP_GREEN && n < 100) begin
            n++;
            tick();
        end
        chk(n == CLR + 1, "R7 all-red gap", n, CLR + 1);
        sense = 4'b0000;
        count_code(2, LAMP_GREEN, n);
        chk(n == MING, "R6 short green with waiter", n, MING);

        // R8: no waiter, held sensor keeps green
        do_reset();
        sense = 4'b0001;
        tick();
        tick();
        repeat (3 * MAXG) tick();
        chk(lam[0] == LAMP_GREEN, "R8 green persists", int'(lam[0]), 1);
        chk(lam[1] == LAMP_RED, "R4 opposite stays red", int'(lam[1]), 0);
        sense = 4'b0000;

        // R9: join on the running axis
        do_reset();
        sense = 4'b0001;
        tick();
        sense = 4'b0000;
        tick();
        sense = 4'b0010;
        tick();
        sense = 4'b0000;
        chk(lam[1] == LAMP_RED, "R9 joiner not yet green", int'(lam[1]), 0);
        tick();
        chk(lam[1] == LAMP_GREEN, "R9 joiner green", int'(lam[1]), 1);
        chk(lam[0] == LAMP_GREEN, "R9 first stays green", int'(lam[0]), 1);

        // R10: both axes held, grants alternate
        do_reset();
        sense = 4'b0101;
        tick();
        tick();
        for (int k = 0; k < 3; k++) begin
            n = 0;
            while (green_axis() < 0 && n < 100) begin
                n++;
                tick();
            end
            chk(green_axis() == (k % 2), "R10 alternation", green_axis(), k % 2);
            count_code((k % 2) ? 2 : 0, LAMP_GREEN, n);
            chk(n == MAXG, "R10 capped under contention", n, MAXG);
        end
        sense = 4'b0000;

        // R11 with R2/R3 under random traffic
        begin
            bit waiting [4];
            int age [4];
            do_reset();
            for (int d = 0; d < 4; d++) begin
                waiting[d] = 0;
                age[d] = 0;
            end
            for (int c = 0; c < 20000; c++) begin
                int a0, a1;
                a0 = (l_ns != 2'b00 || l_sn != 2'b00) ? 1 : 0;
                a1 = (l_we != 2'b00 || l_ew != 2'b00) ? 1 : 0;
                chk(!(a0 == 1 && a1 == 1), "R3 axis exclusion", a0 + a1, 1);
                for (int d = 0; d < 4; d++) begin
                    if (lam[d] == 2'b11)
                        chk(0, "R2 light code", int'(lam[d]), 0);
                    if (lam[d] == LAMP_GREEN) begin
                        if (waiting[d])
                            chk(age[d] <= BOUND, "R11 service bound", age[d], BOUND);
                        waiting[d] = 0;
                    end else if (waiting[d]) begin
                        age[d]++;
                        if (age[d] > BOUND + 1) begin
                            chk(0, "R11 request starved", age[d], BOUND);
                            waiting[d] = 0;
                        end
                    end
                end
                for (int d = 0; d < 4; d++) begin
                    sense[d] = (($urandom % 8) == 0);
                    if (sense[d] && lam[d] != LAMP_GREEN && !waiting[d]) begin
                        waiting[d] = 1;
                        age[d] = 0;
                    end
                end
                tick();
            end
            sense = 4'b0000;
        end

        finish_run();
    end

endmodule